// File: doc/BRIEF.md
# Bit-Manipulation Logic and Extension Unit

This block is a purely combinational datapath slice for an integer execution stage. A 4-bit operation code selects one of twelve functions, which are applied to one or two source operands of XLEN bits: logic with an inverted second operand, an inverted exclusive-or, signed and unsigned minimum and maximum, sub-word sign and zero extension, a per-byte OR reduction, and byte-order reversal. The result appears in the same cycle.

XLEN may be 32 or 64. Decoding of instructions, register file access and pipeline registers belong to the surrounding stage. Bit counting and rotation are done by another unit. A code outside the supported set drives a zero result and raises a flag, so the stage can raise its own fault.

Top module: `bmx_unit`

## Requirements
- R1: Code 0 returns rs1 AND (NOT rs2). Code 1 returns rs1 OR (NOT rs2).
- R2: Code 2 returns NOT (rs1 XOR rs2).
- R3: Code 3 returns the smaller and code 4 the larger of rs1 and rs2, both read as two's-complement signed values. When rs1 < rs2, code 3 returns rs1 and code 4 returns rs2.
- R4: Code 5 returns the smaller and code 6 the larger of rs1 and rs2, both read as unsigned values.
- R5: When rs1 equals rs2, codes 3 to 6 all return that common value.
- R6: Code 7 returns rs1[7:0] with bit 7 copied into every higher bit. rs2 has no effect.
- R7: Code 8 returns rs1[15:0] with bit 15 copied into every higher bit.
- R8: Code 9 returns rs1[15:0] with every higher bit cleared.
- R9: Code 10 makes each result byte 8'h00 when the source byte of rs1 at the same position is zero, and 8'hFF otherwise.
- R10: Code 11 reverses the byte order of rs1 across the full XLEN: byte k (bits 8k+7..8k) moves to byte XLEN/8-1-k.
- R11: Codes 12 to 15 return zero with illegal_op_o at 1. Codes 0 to 11 hold illegal_op_o at 0.
- R12: With XLEN = 32, every function above behaves the same way on the 32-bit word. Sign bits are bit 31 and byte reversal spans four bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see R1 to R11) |
| rs1_i | input | XLEN | First source operand |
| rs2_i | input | XLEN | Second source operand (two-operand codes only) |
| result_o | output | XLEN | Combinational result |
| illegal_op_o | output | 1 | High when op_i is not a supported code |

## Verification
The assertions evaluate whenever an input changes. They assume that op_i, rs1_i and rs2_i hold known 0/1 values, because an X on the code would make the case selection and the legality checks meaningless. The bench drives only defined values, taken from $urandom and from fixed corner patterns, and changes them once per clock so that every evaluation sees settled inputs. Both widths are instantiated side by side, so the 32-bit assumptions on sign-bit position and byte count are checked against the same stimulus as the 64-bit ones.

// File: rtl/bmx_pkg.sv
// Package: shared operation encoding for the bit-manipulation unit.
// Assumes: the 4-bit code is decoded upstream. Values 12..15 are unused.
package bmx_pkg;

    typedef enum logic [3:0] {
        OP_ANDN  = 4'd0,
        OP_ORN   = 4'd1,
        OP_XNOR  = 4'd2,
        OP_MIN   = 4'd3,
        OP_MAX   = 4'd4,
        OP_MINU  = 4'd5,
        OP_MAXU  = 4'd6,
        OP_SEXTB = 4'd7,
        OP_SEXTH = 4'd8,
        OP_ZEXTH = 4'd9,
        OP_ORCB  = 4'd10,
        OP_REV8  = 4'd11
    } bmx_op_e;

    localparam int unsigned BMX_OP_COUNT = 12;

    // Returns 1 for any code that the unit implements.
    function automatic logic bmx_op_legal(input logic [3:0] code);
        return (code < 4'(BMX_OP_COUNT));
    endfunction

endpackage

// File: rtl/bmx_logic.sv
// Module: bitwise logic with an inverted second operand.
// Produces andn, orn and xnor at the same time. The top module selects one.
// Assumes: equal operand widths. No state.
module bmx_logic #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] andn_o,
    output logic [XLEN-1:0] orn_o,
    output logic [XLEN-1:0] xnor_o
);

    logic [XLEN-1:0] b_inv;

    // Invert the second operand once and share it among the three results.
    always_comb begin
        b_inv  = ~b_i;
        andn_o = a_i & b_inv;
        orn_o  = a_i | b_inv;
        xnor_o = a_i ^ b_inv;
    end

endmodule

// File: rtl/bmx_minmax.sv
// Module: signed or unsigned minimum and maximum with one shared comparator.
// For a signed comparison, the sign bits are inverted before an unsigned
// compare. This maps two's-complement order onto unsigned order.
// Assumes: XLEN >= 2. Equal operands return a_i, which equals b_i.
module bmx_minmax #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            signed_i,
    input  logic            take_max_i,
    output logic [XLEN-1:0] res_o
);

    localparam int unsigned MSB = XLEN - 1;

    logic [XLEN-1:0] a_key;
    logic [XLEN-1:0] b_key;
    logic            a_lt_b;

    // Build order-preserving keys and compare them as unsigned values.
    always_comb begin
        a_key  = {a_i[MSB] ^ signed_i, a_i[MSB-1:0]};
        b_key  = {b_i[MSB] ^ signed_i, b_i[MSB-1:0]};
        a_lt_b = (a_key < b_key);
    end

    // Pick the operand that the compare result and the min/max choice call for.
    always_comb begin
        if (take_max_i) res_o = a_lt_b ? b_i : a_i;
        else            res_o = a_lt_b ? a_i : b_i;
    end

endmodule

// File: rtl/bmx_extend.sv
// Module: sub-word extension to XLEN (sign from bit 7, sign from bit 15,
// zero from bit 15).
// Assumes: XLEN > 16.
module bmx_extend #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    output logic [XLEN-1:0] sext_b_o,
    output logic [XLEN-1:0] sext_h_o,
    output logic [XLEN-1:0] zext_h_o
);

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 16;

    // Copy the sub-word sign bit into all upper bits, or clear them.
    always_comb begin
        sext_b_o = {{(XLEN-BYTE_W){a_i[BYTE_W-1]}}, a_i[BYTE_W-1:0]};
        sext_h_o = {{(XLEN-HALF_W){a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
        zext_h_o = {{(XLEN-HALF_W){1'b0}},          a_i[HALF_W-1:0]};
    end

endmodule

// File: rtl/bmx_bytes.sv
// Module: byte-granular functions. Each byte is OR-reduced and spread to
// all eight bits, and the byte order is reversed.
// Assumes: XLEN is a multiple of 8.
module bmx_bytes #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    output logic [XLEN-1:0] orc_o,
    output logic [XLEN-1:0] rev_o
);

    localparam int unsigned NBYTES = XLEN / 8;

    // One lane per byte: an OR reduction and a mirrored placement.
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign orc_o[8*k +: 8]              = {8{|a_i[8*k +: 8]}};
        assign rev_o[8*(NBYTES-1-k) +: 8]   = a_i[8*k +: 8];
    end

endmodule

// File: rtl/bmx_unit.sv
// Module: top of the bit-manipulation unit. Passes the operands to the
// function slices and selects one result with the operation code.
// Unsupported codes give zero and raise illegal_op_o.
// Assumes: XLEN is 32 or 64. Fully combinational, with no clock or reset.
module bmx_unit
    import bmx_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] rs1_i,
    input  logic [XLEN-1:0] rs2_i,
    output logic [XLEN-1:0] result_o,
    output logic            illegal_op_o
);

    logic [XLEN-1:0] andn_r, orn_r, xnor_r;
    logic [XLEN-1:0] mm_r;
    logic [XLEN-1:0] sxb_r, sxh_r, zxh_r;
    logic [XLEN-1:0] orc_r, rev_r;
    logic            mm_signed, mm_max;

    bmx_logic #(.XLEN(XLEN)) u_logic (
        .a_i    (rs1_i),
        .b_i    (rs2_i),
        .andn_o (andn_r),
        .orn_o  (orn_r),
        .xnor_o (xnor_r)
    );

    // Derive the comparator mode from the operation code.
    always_comb begin
        mm_signed = (op_i == OP_MIN)  || (op_i == OP_MAX);
        mm_max    = (op_i == OP_MAX)  || (op_i == OP_MAXU);
    end

    bmx_minmax #(.XLEN(XLEN)) u_minmax (
        .a_i        (rs1_i),
        .b_i        (rs2_i),
        .signed_i   (mm_signed),
        .take_max_i (mm_max),
        .res_o      (mm_r)
    );

    bmx_extend #(.XLEN(XLEN)) u_extend (
        .a_i      (rs1_i),
        .sext_b_o (sxb_r),
        .sext_h_o (sxh_r),
        .zext_h_o (zxh_r)
    );

    bmx_bytes #(.XLEN(XLEN)) u_bytes (
        .a_i   (rs1_i),
        .orc_o (orc_r),
        .rev_o (rev_r)
    );

    // Final result select. Unsupported codes give zero.
    always_comb begin
        case (op_i)
            OP_ANDN:                          result_o = andn_r;
            OP_ORN:                           result_o = orn_r;
            OP_XNOR:                          result_o = xnor_r;
            OP_MIN, OP_MAX, OP_MINU, OP_MAXU: result_o = mm_r;
            OP_SEXTB:                         result_o = sxb_r;
            OP_SEXTH:                         result_o = sxh_r;
            OP_ZEXTH:                         result_o = zxh_r;
            OP_ORCB:                          result_o = orc_r;
            OP_REV8:                          result_o = rev_r;
            default:                          result_o = '0;
        endcase
    end

    // Flag codes outside the supported set.
    always_comb illegal_op_o = !bmx_op_legal(op_i);

endmodule

// File: rtl/bmx_unit_chk.sv
// Checker: immediate assertions on the ports of bmx_unit, attached by bind.
// Assumes: op_i, rs1_i and rs2_i carry known values.
module bmx_unit_chk
    import bmx_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input logic [3:0]      op_i,
    input logic [XLEN-1:0] rs1_i,
    input logic [XLEN-1:0] rs2_i,
    input logic [XLEN-1:0] result_o,
    input logic            illegal_op_o
);

    localparam int unsigned NBYTES = XLEN / 8;

    // Check each port relation while the code that enables it is applied.
    always_comb begin
        if (op_i == OP_ANDN)
            assert_andn_bits_R1: assert (((result_o & rs2_i) == '0) && ((result_o & ~rs1_i) == '0))
                else $error("ANDN result sets a forbidden bit");
        if (op_i == OP_ORN)
            assert_orn_bits_R1: assert (((rs1_i & ~result_o) == '0) && ((~rs2_i & ~result_o) == '0))
                else $error("ORN result misses a required bit");
        if (op_i == OP_XNOR)
            assert_xnor_R2: assert ((result_o ^ rs1_i ^ rs2_i) == '1)
                else $error("XNOR parity broken");
        if (op_i == OP_MIN || op_i == OP_MAX)
            assert_signed_pick_R3: assert (result_o == rs1_i || result_o == rs2_i)
                else $error("signed min/max returned a foreign value");
        if (op_i == OP_MAXU)
            assert_umax_bound_R4: assert (result_o >= rs1_i && result_o >= rs2_i)
                else $error("MAXU below an operand");
        if (op_i == OP_MINU)
            assert_umin_bound_R4: assert (result_o <= rs1_i && result_o <= rs2_i)
                else $error("MINU above an operand");
        if ((op_i >= OP_MIN) && (op_i <= OP_MAXU) && (rs1_i == rs2_i))
            assert_equal_ops_R5: assert (result_o == rs1_i)
                else $error("min/max of equal operands differs");
        if (op_i == OP_SEXTB)
            assert_sext_byte_R6: assert (result_o[7:0] == rs1_i[7:0] &&
                ($countones(result_o[XLEN-1:7]) == 0 || $countones(result_o[XLEN-1:7]) == XLEN-7))
                else $error("SEXT.B upper bits not uniform");
        if (op_i == OP_SEXTH)
            assert_sext_half_R7: assert (result_o[15:0] == rs1_i[15:0] &&
                ($countones(result_o[XLEN-1:15]) == 0 || $countones(result_o[XLEN-1:15]) == XLEN-15))
                else $error("SEXT.H upper bits not uniform");
        if (op_i == OP_ZEXTH)
            assert_zext_half_R8: assert (result_o[15:0] == rs1_i[15:0] && $countones(result_o[XLEN-1:16]) == 0)
                else $error("ZEXT.H upper bits set");
        if (op_i == OP_ORCB)
            for (int k = 0; k < NBYTES; k++)
                assert_orc_byte_R9: assert (result_o[8*k +: 8] == ((rs1_i[8*k +: 8] == 8'h00) ? 8'h00 : 8'hFF))
                    else $error("ORC.B byte %0d wrong", k);
        if (op_i == OP_REV8)
            assert_rev_popcount_R10: assert ($countones(result_o) == $countones(rs1_i))
                else $error("REV8 changed the bit count");
        if (op_i >= 4'd12)
            assert_illegal_zero_R11: assert (illegal_op_o && result_o == '0)
                else $error("unsupported code not flagged or not zero");
        else
            assert_legal_flag_R11: assert (!illegal_op_o)
                else $error("supported code flagged illegal");
    end

endmodule

bind bmx_unit bmx_unit_chk #(.XLEN(XLEN)) u_chk (
    .op_i         (op_i),
    .rs1_i        (rs1_i),
    .rs2_i        (rs2_i),
    .result_o     (result_o),
    .illegal_op_o (illegal_op_o)
);

// File: tb/sim_bmx_unit.sv
// Bench: drives the 64-bit and 32-bit units from the same stimulus and
// compares both against a behavioural model on every clock.
module sim_bmx_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [63:0] rs1 = '0;
    logic [63:0] rs2 = '0;
    logic [63:0] r64;
    logic [31:0] r32;
    logic        ill64, ill32;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bmx_unit #(.XLEN(64)) u0 (
        .op_i(op), .rs1_i(rs1), .rs2_i(rs2), .result_o(r64), .illegal_op_o(ill64)
    );

    bmx_unit #(.XLEN(32)) u1 (
        .op_i(op), .rs1_i(rs1[31:0]), .rs2_i(rs2[31:0]), .result_o(r32), .illegal_op_o(ill32)
    );

    // Model: computes the expected result for width w from the requirement text.
    function automatic logic [63:0] model(input int w, input int code,
                                          input logic [63:0] a_in, input logic [63:0] b_in);
        logic [63:0] m, a, b, r;
        longint sa, sb;
        m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        a = a_in & m;
        b = b_in & m;
        sa = (w == 64) ? longint'(a) : longint'({{32{a[31]}}, a[31:0]});
        sb = (w == 64) ? longint'(b) : longint'({{32{b[31]}}, b[31:0]});
        r = '0;
        case (code)
            0:  r = a & ~b;
            1:  r = a | ~b;
            2:  r = ~(a ^ b);
            3:  r = (sa < sb) ? a : b;
            4:  r = (sa < sb) ? b : a;
            5:  r = (a < b) ? a : b;
            6:  r = (a < b) ? b : a;
            7:  r = {{56{a[7]}}, a[7:0]};
            8:  r = {{48{a[15]}}, a[15:0]};
            9:  r = {48'h0, a[15:0]};
            10: for (int i = 0; i < w/8; i++) r[8*i +: 8] = (a[8*i +: 8] == 8'h00) ? 8'h00 : 8'hFF;
            11: for (int i = 0; i < w/8; i++) r[8*(w/8-1-i) +: 8] = a[8*i +: 8];
            default: r = '0;
        endcase
        return r & m;
    endfunction

    function automatic string tag_of(input int code);
        case (code)
            0, 1:    return "R1";
            2:       return "R2";
            3, 4:    return "R3";
            5, 6:    return "R4";
            7:       return "R6";
            8:       return "R7";
            9:       return "R8";
            10:      return "R9";
            11:      return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d rs1=%h rs2=%h actual=%h expected=%h", req, op, rs1, rs2, act, exp);
        end
    endtask

    // Apply one vector on a rising edge, then compare both widths at the falling edge.
    task automatic apply(input int code, input logic [63:0] a, input logic [63:0] b, input string req);
        @(posedge clk);
        op  = 4'(code);
        rs1 = a;
        rs2 = b;
        @(negedge clk);
        check(req, r64, model(64, code, a, b));
        check({"R12 ", req}, {32'h0, r32}, model(32, code, a, b));
        check({req, " flag"}, {63'h0, ill64}, {63'h0, (code >= 12)});
        check({"R11 R12 flag"}, {63'h0, ill32}, {63'h0, (code >= 12)});
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // Stimulus: reset, directed corners, then random vectors.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("reset R1", r64, 64'h0);
        rst_n = 1'b1;

        // R3: signed boundaries (most negative against most positive)
        apply(3, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R3");
        apply(4, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R3");
        apply(3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R3");
        apply(4, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, "R3");
        // R4: the same patterns read as unsigned values
        apply(5, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R4");
        apply(6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R4");
        // R5: equal operands in every compare mode
        for (int c = 3; c <= 6; c++) begin
            apply(c, 64'hDEAD_BEEF_8000_0001, 64'hDEAD_BEEF_8000_0001, "R5");
            apply(c, 64'h0, 64'h0, "R5");
        end
        // R6 to R8: sign bits set and clear, rs2 changed to show it has no effect
        apply(7, 64'h0123_4567_89AB_CD80, 64'h0, "R6");
        apply(7, 64'h0123_4567_89AB_CD80, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        apply(7, 64'hFFFF_FFFF_FFFF_FF7F, 64'h5, "R6");
        apply(8, 64'h0000_0000_0000_8000, 64'h0, "R7");
        apply(8, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0, "R7");
        apply(9, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R8");
        // R9: some bytes zero, some holding a single set bit
        apply(10, 64'h0001_0080_0000_1000, 64'h0, "R9");
        apply(10, 64'h0, 64'h0, "R9");
        // R10: distinct bytes to show the mirrored order
        apply(11, 64'h0102_0304_0506_0708, 64'h0, "R10");
        // R11: every unsupported code
        for (int c = 12; c < 16; c++) apply(c, rnd64(), rnd64(), "R11");

        // Random sweep over all codes, with bytes zeroed now and then for ORC.B
        for (int n = 0; n < 3000; n++) begin
            int c;
            logic [63:0] a, b;
            c = n % 16;
            a = rnd64();
            b = (n % 7 == 0) ? a : rnd64();
            if (n % 3 == 0) a = a & {8{{7'h0, 1'b1} | {8{$urandom_range(0, 1) == 1}}}};
            apply(c, a, b, (n % 7 == 0 && c >= 3 && c <= 6) ? "R5" : tag_of(c));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: stops a hung run, counting it as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule